// File: doc/BRIEF.md
# Mask-Driven Bit Expand Unit

This unit scatters the bits of a data word into the positions picked out by a mask word of the same width. Successive data bits go, in order, to the set bits of the mask. Every result position whose mask bit is clear reads zero. In right mode the data word is used starting from its least significant bit, and the set mask bits are filled from bit 0 upward. Left mode is the mirror image: data bits are taken from the most significant end and placed into the set mask bits starting from the top.

The unit is iterative. A start pulse while it is idle latches the data, the mask and the direction. It then examines `LANES` mask bits per cycle, so one operation takes `WIDTH/LANES` busy cycles. A one-cycle done pulse then presents the result together with the number of set mask bits. Typical uses are spreading packed fields into sparse layouts, building interleaved coordinate indices, and undoing a mask-driven pack.

Top module: `bit_expand_unit`

## Requirements
- R1: While reset is asserted and right after it, `busy_o` and `done_o` are 0 and `result_o` and `count_o` are 0. Reset during an operation abandons it.
- R2: Right mode (`left_i`=0): scanning the mask from bit 0 upward, the k-th set mask bit (k counted from 0) receives bit k of the data. With mask 0x00F0 the result is (data & 0xF) << 4. Data 1 yields the lowest set bit of the mask, so XOR with the mask clears that bit. Data 3 under 0xAAAA ORed with data 5 under 0x5555 gives 0x001B.
- R3: Left mode (`left_i`=1) equals bit-reversing the data and the mask, applying right mode, and bit-reversing the result. With 0xB000 (top nibble 1011) under 0x5000 the result is 0x4000.
- R4: Result bits at cleared mask positions are 0. Data bits at or above position popcount(mask) are dropped without effect. An all-zero mask gives 0.
- R5: If the data has no set bits outside the mask, right-mode expansion of its right-packed form under the same mask returns the data. If the data is below 2^popcount(mask), right-packing the expanded result under the mask returns the data.
- R6: A start accepted at a clock edge makes `busy_o` high for exactly `WIDTH/LANES` cycles. This is followed by one cycle of `done_o`. `busy_o` and `done_o` are never high together.
- R7: From the done pulse until the next accepted start, `result_o` and `count_o` hold their values whatever the other inputs do.
- R8: At the done pulse `count_o` equals the number of set bits in the latched mask.
- R9: A start pulse while `busy_o` is high is ignored. The running operation completes with its own operands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, taken only when idle |
| left_i | input | 1 | Direction: 0 right mode, 1 left mode |
| data_i | input | WIDTH | Data word to scatter |
| mask_i | input | WIDTH | Mask word selecting destination positions |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | WIDTH | Expanded result, valid from done until next start |
| count_o | output | $clog2(WIDTH+1) | Number of set mask bits |

## Verification
If the start edge is counted as cycle 0, `busy_o` is high after each of edges 0 to `WIDTH/LANES`-1. `done_o`, `result_o` and `count_o` become valid after edge `WIDTH/LANES`. The bench raises start at a falling edge and drops it at the next one. It then samples busy and done at every following falling edge, expecting done at exactly the `WIDTH/LANES`-th sample, and reads the result and the count there. The hold and ignore checks wait several further falling edges after done, or after a start issued while busy, before they read the ports again.

// File: rtl/bexp_pkg.sv
package bexp_pkg;
  typedef enum logic {
    SCAN_FROM_LSB = 1'b0,
    SCAN_FROM_MSB = 1'b1
  } scan_dir_e;
endpackage

// File: rtl/bexp_reverse.sv
module bexp_reverse #(
  parameter int W = 16
) (
  input  logic [W-1:0] in_v,
  output logic [W-1:0] out_v
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign out_v[i] = in_v[W-1-i];
  end
endmodule

// File: rtl/bexp_lane_slice.sv
// Deposits source bits into one group of LANES mask positions.
module bexp_lane_slice #(
  parameter int WIDTH = 16,
  parameter int LANES = 4,
  localparam int UW = $clog2(LANES + 1)
) (
  input  logic [LANES-1:0] mask_bits,
  input  logic [WIDTH-1:0] src_bits,
  output logic [LANES-1:0] dep_bits,
  output logic [UW-1:0]    taken
);
  always_comb begin
    logic [UW-1:0] k;
    k = '0;
    for (int j = 0; j < LANES; j++) begin
      dep_bits[j] = mask_bits[j] & src_bits[k];
      k = k + UW'(mask_bits[j]);
    end
    taken = k;
  end
endmodule

// File: rtl/bit_expand_unit.sv
module bit_expand_unit
  import bexp_pkg::*;
#(
  parameter int WIDTH = 16,
  parameter int LANES = 4,
  localparam int CW = $clog2(WIDTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             left_i,
  input  logic [WIDTH-1:0] data_i,
  input  logic [WIDTH-1:0] mask_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [WIDTH-1:0] result_o,
  output logic [CW-1:0]    count_o
);
  localparam int STEPS = WIDTH / LANES;
  localparam int SW    = (STEPS > 1) ? $clog2(STEPS) : 1;
  localparam int UW    = $clog2(LANES + 1);

  // state registers
  logic             busy_q, busy_nx;
  logic             done_q, done_nx;
  scan_dir_e        dir_q,  dir_nx;
  logic [WIDTH-1:0] src_q,  src_nx;
  logic [WIDTH-1:0] msk_q,  msk_nx;
  logic [WIDTH-1:0] acc_q,  acc_nx;
  logic [CW-1:0]    cnt_q,  cnt_nx;
  logic [SW-1:0]    step_q, step_nx;
  logic             accept, load_en;

  // datapath wires
  logic [WIDTH-1:0] data_rev, mask_rev, acc_rev;
  logic [LANES-1:0] dep;
  logic [UW-1:0]    taken;

  bexp_reverse #(.W(WIDTH)) u_rev_data (.in_v(data_i), .out_v(data_rev));
  bexp_reverse #(.W(WIDTH)) u_rev_mask (.in_v(mask_i), .out_v(mask_rev));
  bexp_reverse #(.W(WIDTH)) u_rev_acc  (.in_v(acc_q),  .out_v(acc_rev));

  bexp_lane_slice #(.WIDTH(WIDTH), .LANES(LANES)) u_slice (
    .mask_bits (msk_q[LANES-1:0]),
    .src_bits  (src_q),
    .dep_bits  (dep),
    .taken     (taken)
  );

  assign accept  = start_i & ~busy_q;
  assign load_en = accept | busy_q;

  // next-state logic
  always_comb begin
    busy_nx = busy_q;
    done_nx = 1'b0;
    dir_nx  = dir_q;
    src_nx  = src_q;
    msk_nx  = msk_q;
    acc_nx  = acc_q;
    cnt_nx  = cnt_q;
    step_nx = step_q;
    if (accept) begin
      busy_nx = 1'b1;
      dir_nx  = left_i ? SCAN_FROM_MSB : SCAN_FROM_LSB;
      src_nx  = left_i ? data_rev : data_i;
      msk_nx  = left_i ? mask_rev : mask_i;
      acc_nx  = '0;
      cnt_nx  = '0;
      step_nx = SW'(STEPS - 1);
    end else if (busy_q) begin
      src_nx = src_q >> taken;
      msk_nx = msk_q >> LANES;
      acc_nx = acc_q >> LANES;
      acc_nx[WIDTH-1 -: LANES] = dep;
      cnt_nx = cnt_q + CW'(taken);
      if (step_q == '0) begin
        busy_nx = 1'b0;
        done_nx = 1'b1;
      end else begin
        step_nx = step_q - 1'b1;
      end
    end
  end

  // control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      busy_q <= busy_nx;
      done_q <= done_nx;
    end
  end

  // datapath registers, enabled only on accept or while working
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= SCAN_FROM_LSB;
      src_q  <= '0;
      msk_q  <= '0;
      acc_q  <= '0;
      cnt_q  <= '0;
      step_q <= '0;
    end else if (load_en) begin
      dir_q  <= dir_nx;
      src_q  <= src_nx;
      msk_q  <= msk_nx;
      acc_q  <= acc_nx;
      cnt_q  <= cnt_nx;
      step_q <= step_nx;
    end
  end

  assign busy_o   = busy_q;
  assign done_o   = done_q;
  assign result_o = (dir_q == SCAN_FROM_MSB) ? acc_rev : acc_q;
  assign count_o  = cnt_q;
endmodule

// File: rtl/bit_expand_unit_chk.sv
module bit_expand_unit_chk #(
  parameter int WIDTH = 16,
  parameter int LANES = 4,
  localparam int CW = $clog2(WIDTH + 1),
  localparam int STEPS = WIDTH / LANES
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic [WIDTH-1:0] mask_i,
  input logic             busy_o,
  input logic             done_o,
  input logic [WIDTH-1:0] result_o,
  input logic [CW-1:0]    count_o
);
  logic [WIDTH-1:0] mask_cap;
  logic [CW-1:0]    lat_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_cap <= '0;
      lat_cnt  <= '0;
    end else if (start_i && !busy_o) begin
      mask_cap <= mask_i;
      lat_cnt  <= '0;
    end else if (busy_o) begin
      lat_cnt  <= lat_cnt + 1'b1;
    end
  end

  AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(busy_o && done_o)); // R6
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) done_o |=> !done_o); // R6
  AST_START_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n) (start_i && !busy_o) |=> busy_o); // R6
  AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n) done_o |-> (lat_cnt == CW'(STEPS))); // R6
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (!busy_o && !start_i) |=> ($stable(result_o) && $stable(count_o))); // R7
  AST_NO_STRAY_BITS: assert property (@(posedge clk) disable iff (!rst_n) done_o |-> ((result_o & ~mask_cap) == '0)); // R4
  AST_MASK_COUNT: assert property (@(posedge clk) disable iff (!rst_n) done_o |-> (count_o == CW'($countones(mask_cap)))); // R8
endmodule

bind bit_expand_unit bit_expand_unit_chk #(.WIDTH(WIDTH), .LANES(LANES)) u_chk (.*);

// File: tb/bit_expand_unit_test.sv
module bit_expand_unit_test;
  localparam int WIDTH = 16;
  localparam int LANES = 4;
  localparam int STEPS = WIDTH / LANES;
  localparam int CW    = $clog2(WIDTH + 1);
  localparam int NVEC  = 14;

  // {left, data, mask, expected}
  localparam logic [48:0] VEC [NVEC] = '{
    {1'b0, 16'h000B, 16'h0005, 16'h0005},  // R2 nibble example
    {1'b1, 16'hB000, 16'h5000, 16'h4000},  // R3 nibble example
    {1'b0, 16'h0003, 16'hAAAA, 16'h000A},  // R2 odd lanes
    {1'b0, 16'h0005, 16'h5555, 16'h0011},  // R2 even lanes
    {1'b0, 16'h1234, 16'h00F0, 16'h0040},  // R2 shift form
    {1'b0, 16'h0001, 16'h0B40, 16'h0040},  // R2 lowest set bit
    {1'b0, 16'hBEEF, 16'hFFFF, 16'hBEEF},  // R2 full mask
    {1'b1, 16'hBEEF, 16'hFFFF, 16'hBEEF},  // R3 full mask
    {1'b0, 16'hFFFF, 16'h0000, 16'h0000},  // R4 empty mask
    {1'b0, 16'hFFFF, 16'h0101, 16'h0101},  // R4 surplus dropped
    {1'b1, 16'h8001, 16'h00FF, 16'h0080},  // R3 top bit to top lane
    {1'b0, 16'hA5C3, 16'hF00F, 16'hC003},  // R2 split mask
    {1'b1, 16'hA5C3, 16'hF00F, 16'hA005},  // R3 split mask
    {1'b1, 16'h0000, 16'hFFFF, 16'h0000}   // R3 zero data
  };

  logic             clk = 1'b0;
  logic             rst_n;
  logic             start_i, left_i;
  logic [WIDTH-1:0] data_i, mask_i;
  logic             busy_o, done_o;
  logic [WIDTH-1:0] result_o;
  logic [CW-1:0]    count_o;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  bit_expand_unit #(.WIDTH(WIDTH), .LANES(LANES)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .left_i(left_i),
    .data_i(data_i), .mask_i(mask_i), .busy_o(busy_o), .done_o(done_o),
    .result_o(result_o), .count_o(count_o)
  );

  function automatic logic [WIDTH-1:0] pack_ref(logic [WIDTH-1:0] x, logic [WIDTH-1:0] m);
    int j = 0;
    pack_ref = '0;
    for (int i = 0; i < WIDTH; i++) begin
      if (m[i]) begin
        pack_ref[j] = x[i];
        j++;
      end
    end
  endfunction

  task automatic check_val(string tag, logic [WIDTH-1:0] act, logic [WIDTH-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_op(input logic dir, input logic [WIDTH-1:0] x, input logic [WIDTH-1:0] m,
                        output logic [WIDTH-1:0] res, output logic [CW-1:0] cnt);
    bit ok = 1'b1;
    @(negedge clk);
    start_i = 1'b1; left_i = dir; data_i = x; mask_i = m;
    @(negedge clk);
    start_i = 1'b0;
    for (int k = 0; k <= STEPS; k++) begin
      if (k > 0) @(negedge clk);
      if (k < STEPS) ok = ok & busy_o & ~done_o;
      else           ok = ok & done_o & ~busy_o;
    end
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL R6 latency actual=busy%b/done%b expected=busy0/done1", busy_o, done_o);
    end
    res = result_o;
    cnt = count_o;
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL R6 watchdog actual=hung expected=complete");
      summary();
      $finish;
    end
  end

  initial begin
    logic [WIDTH-1:0] r, r2, c;
    logic [CW-1:0]    n;
    rst_n = 1'b0; start_i = 1'b0; left_i = 1'b0; data_i = '0; mask_i = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check_val("R1 reset busy/done", {14'd0, busy_o, done_o}, '0);
    check_val("R1 reset result", result_o, '0);
    check_val("R1 reset count", WIDTH'(count_o), '0);
    rst_n = 1'b1;
    @(negedge clk);

    // table walk: R2 R3 R4 values, R8 counts
    for (int v = 0; v < NVEC; v++) begin
      run_op(VEC[v][48], VEC[v][47:32], VEC[v][31:16], r, n);
      check_val($sformatf("R2/R3/R4 vector %0d", v), r, VEC[v][15:0]);
      check_val($sformatf("R8 count vector %0d", v), WIDTH'(n), WIDTH'($countones(VEC[v][31:16])));
    end

    // R2 interleave and clear-lowest-bit identities
    run_op(1'b0, 16'h0003, 16'hAAAA, r, n);
    run_op(1'b0, 16'h0005, 16'h5555, r2, n);
    check_val("R2 interleave", r | r2, 16'h001B);
    run_op(1'b0, 16'h0001, 16'h0B40, r, n);
    check_val("R2 clear lowest", r ^ 16'h0B40, 16'h0B00);

    // R5 inverse relations
    c = pack_ref(16'h1428, 16'h3C3C);
    run_op(1'b0, c, 16'h3C3C, r, n);
    check_val("R5 expand of pack", r, 16'h1428);
    run_op(1'b0, 16'h002D, 16'h3C3C, r, n);
    check_val("R5 pack of expand", pack_ref(r, 16'h3C3C), 16'h002D);

    // R7 hold after done with changing inputs and no start
    run_op(1'b1, 16'hA5C3, 16'hF00F, r, n);
    data_i = 16'h1111; mask_i = 16'hFFFF; left_i = 1'b0;
    repeat (6) @(negedge clk);
    check_val("R7 result held", result_o, 16'hA005);
    check_val("R7 count held", WIDTH'(count_o), 16'd8);

    // R9 start while busy ignored
    @(negedge clk);
    start_i = 1'b1; left_i = 1'b0; data_i = 16'h000F; mask_i = 16'h00FF;
    @(negedge clk);
    start_i = 1'b0;
    @(negedge clk);
    start_i = 1'b1; left_i = 1'b1; data_i = 16'hFFFF; mask_i = 16'hFFFF;
    @(negedge clk);
    start_i = 1'b0;
    for (int k = 0; k < 20 && !done_o; k++) @(negedge clk);
    check_val("R9 first operands kept", result_o, 16'h000F);
    check_val("R9 count of first mask", WIDTH'(count_o), 16'd8);
    repeat (4) @(negedge clk);
    check_val("R9 no second run", {15'd0, busy_o}, '0);

    // R1 reset mid-operation
    @(negedge clk);
    start_i = 1'b1; left_i = 1'b0; data_i = 16'hFFFF; mask_i = 16'hFFFF;
    @(negedge clk);
    start_i = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    check_val("R1 mid-run reset busy/done", {14'd0, busy_o, done_o}, '0);
    check_val("R1 mid-run reset result", result_o, '0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    finished = 1'b1;
    summary();
    $finish;
  end
endmodule